// File: doc/BRIEF.md
# Text-mode glyph pixel generator with descender shift

This block turns a character code, the scan line within the character cell and the dot column into one pixel bit for a text display. It holds a built-in glyph store for 128 characters. Every glyph is a 7-dot-wide, 9-row dot matrix placed inside a 12-line cell that is 8 dots wide; the eighth dot is the gap between characters.

A per-glyph flag makes the 9-row matrix start lower in the cell, so characters with descenders are drawn three lines down. Only nine rows are stored for any glyph, never twelve. Cell lines that the glyph does not cover come out blank.

One register stage sits between the inputs and the pixel. A video timing generator drives code, row and column once per dot clock and sees each pixel one clock later. An invert input, delayed by the same stage, gives reverse video.

Top module: `glyph_pixel_gen`

## Requirements
- R1: While `rst_n` is low, `pixel` is 0 whatever the other inputs are.
- R2: `pixel` reflects the `code`, `row`, `col` and `invert` values captured at the previous rising clock edge (one cycle of latency).
- R3: For a visible dot, column 0 shows bit 6 of the glyph row byte and column c (0..6) shows bit 6-c.
- R4: Column 7 is the inter-character gap and its pixel is 0 before inversion.
- R5: For unshifted glyphs (codes 0..95), cell line r in 0..8 shows glyph row r, and cell lines 9..11 are blank.
- R6: For shifted glyphs (codes 96..127), cell lines 0..2 are blank and cell line r in 3..11 shows glyph row r-3.
- R7: A cell line index of 12..15 gives a blank pixel before inversion.
- R8: The glyph store contents are fixed. Glyph row g (0..8) of code c has bits 6:0 equal to (5*c + 37*g + 11) mod 128. Store slots 9..15 of every code read as zero. Bit 7 of slot 0 is the shift flag, and it is 1 exactly for codes 96..127.
- R9: `pixel` is the glyph dot XOR the captured `invert`, so blank dots come out as 1 when `invert` is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| code | input | 7 | Character code |
| row | input | 4 | Scan line within the character cell |
| col | input | 3 | Dot column within the cell, 7 = gap |
| invert | input | 1 | Reverse-video select |
| pixel | output | 1 | Pixel bit, one cycle after the inputs |

## Verification
The assertions assume that the inputs are stable around each rising edge and that one set of code, row, column and invert belongs to exactly one output cycle. They also wait one cycle after reset before using past input values. The bench changes inputs only on falling edges and samples `pixel` on the next falling edge. Its sweep covers every code, every row index including 12..15, and every column, so all blank-region properties are reached with both values of the shift flag.

// File: rtl/glyph_pixel_gen.sv
module glyph_pixel_gen #(
  parameter int CODE_W     = 7,
  parameter int ROW_W      = 4,
  parameter int COL_W      = 3,
  parameter int GLYPH_W    = 7,
  parameter int GLYPH_ROWS = 9,
  parameter int CELL_ROWS  = 12,
  parameter int SHIFT      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code,
  input  logic [ROW_W-1:0]  row,
  input  logic [COL_W-1:0]  col,
  input  logic              invert,
  output logic              pixel
);
  localparam int DEPTH  = (1 << CODE_W) * (1 << ROW_W);
  localparam int ADDR_W = CODE_W + ROW_W;

  function automatic logic [7:0] glyph_byte(int c, int s);
    logic [7:0] b;
    b = 8'h00;
    if (s < GLYPH_ROWS) b[6:0] = 7'((5 * c + 37 * s + 11) % 128);
    if (s == 0 && c >= 96) b[7] = 1'b1;
    return b;
  endfunction

  logic [7:0] store [DEPTH];
  initial begin
    for (int i = 0; i < DEPTH; i++)
      store[i] = glyph_byte(i >> ROW_W, i % (1 << ROW_W));
  end

  logic              shifted;
  logic [ROW_W:0]    grow;
  logic              in_glyph;
  logic [ADDR_W-1:0] addr;

  assign shifted  = store[{code, {ROW_W{1'b0}}}][7];
  assign grow     = {1'b0, row} - (shifted ? (ROW_W+1)'(SHIFT) : '0);
  assign in_glyph = (row < ROW_W'(CELL_ROWS)) && !grow[ROW_W] &&
                    (grow[ROW_W-1:0] < ROW_W'(GLYPH_ROWS));
  assign addr     = {code, grow[ROW_W-1:0]};

  logic [GLYPH_W-1:0] dots_q;
  logic [COL_W-1:0]   col_q;
  logic               inv_q;
  logic               armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dots_q  <= '0;
      col_q   <= '0;
      inv_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      dots_q  <= in_glyph ? store[addr][GLYPH_W-1:0] : '0;
      col_q   <= col;
      inv_q   <= invert;
      armed_q <= 1'b1;
    end
  end

  logic [COL_W-1:0] bit_sel;
  logic             dot;
  assign bit_sel = COL_W'(GLYPH_W - 1) - col_q;
  assign dot     = (col_q < COL_W'(GLYPH_W)) && dots_q[bit_sel];
  assign pixel   = dot ^ inv_q;

  AST_GAP_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && $past(col) >= COL_W'(GLYPH_W) |-> pixel == $past(invert)); // R4
  AST_ROW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && $past(row) >= ROW_W'(CELL_ROWS) |-> pixel == $past(invert)); // R7
  AST_SHIFT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && $past(shifted) && $past(row) < ROW_W'(SHIFT) |-> pixel == $past(invert)); // R6
  AST_PLAIN_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && !$past(shifted) && $past(row) >= ROW_W'(GLYPH_ROWS) |-> pixel == $past(invert)); // R5
  AST_RESET_LOW: assert property (@(posedge clk)
    !rst_n |-> !pixel); // R1
endmodule

// File: tb/tb_glyph_pixel_gen.sv
module tb_glyph_pixel_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] code = '0;
  logic [3:0] row = '0;
  logic [2:0] col = '0;
  logic       invert = 1'b0;
  logic       pixel;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  glyph_pixel_gen dut (.clk(clk), .rst_n(rst_n), .code(code), .row(row),
                       .col(col), .invert(invert), .pixel(pixel));

  function automatic logic model(int c, int r, int k, logic inv);
    int g;
    logic [6:0] p;
    logic d;
    d = 1'b0;
    g = (c >= 96) ? r - 3 : r;
    if (r < 12 && g >= 0 && g <= 8 && k < 7) begin
      p = 7'((5 * c + 37 * g + 11) % 128);
      d = p[6 - k];
    end
    return d ^ inv;
  endfunction

  task automatic check(logic exp, string req);
    checks++;
    if (pixel !== exp) begin
      errors++;
      $display("FAIL %s code=%0d row=%0d col=%0d inv=%0b actual=%0b expected=%0b",
               req, code, row, col, invert, pixel, exp);
    end
  endtask

  task automatic apply(int c, int r, int k, logic inv, string req);
    code = 7'(c); row = 4'(r); col = 3'(k); invert = inv;
    @(negedge clk);
    check(model(c, r, k, inv), req);
  endtask

  // {invert, code, row, col}
  localparam int NV = 14;
  localparam logic [14:0] VEC [NV] = '{
    {1'b0, 7'd0,   4'd0,  3'd0},   // R3 R8
    {1'b0, 7'd0,   4'd0,  3'd6},   // R3
    {1'b0, 7'd65,  4'd4,  3'd2},   // R5
    {1'b0, 7'd65,  4'd9,  3'd1},   // R5 blank tail
    {1'b0, 7'd65,  4'd11, 3'd5},   // R5
    {1'b0, 7'd100, 4'd0,  3'd3},   // R6 blank top
    {1'b0, 7'd100, 4'd3,  3'd0},   // R6 glyph row 0
    {1'b0, 7'd100, 4'd11, 3'd4},   // R6 glyph row 8
    {1'b0, 7'd127, 4'd12, 3'd2},   // R7
    {1'b0, 7'd10,  4'd15, 3'd0},   // R7
    {1'b0, 7'd33,  4'd2,  3'd7},   // R4
    {1'b1, 7'd33,  4'd2,  3'd7},   // R9 gap inverted
    {1'b1, 7'd96,  4'd1,  3'd1},   // R9 blank inverted
    {1'b1, 7'd50,  4'd5,  3'd3}    // R9
  };

  initial begin
    #100000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    invert = 1'b1; code = 7'd5; row = 4'd0; col = 3'd0;
    repeat (3) @(negedge clk);
    check(1'b0, "R1");
    rst_n = 1'b1;
    check(1'b0, "R1");
    invert = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++)
      apply(int'(VEC[i][13:7]), int'(VEC[i][6:3]), int'(VEC[i][2:0]), VEC[i][14], "R3/R5/R6/R9 table");

    // R2: output holds the previous result until the next rising edge
    apply(0, 0, 2, 1'b0, "R2 setup");
    begin
      logic prev;
      prev = pixel;
      code = 7'd0; row = 4'd0; col = 3'd2; invert = 1'b1;
      #5;
      check(prev, "R2 before edge");
      @(negedge clk);
      check(model(0, 0, 2, 1'b1), "R2 after edge");
    end

    // Full sweep: R8 contents, R5 R6 R7 row placement, R3 R4 columns
    for (int c = 0; c < 128; c++)
      for (int r = 0; r < 16; r++)
        for (int k = 0; k < 8; k++)
          apply(c, r, k, 1'(((c + r + k) % 5) == 0), "R8 sweep");

    // R1: reset mid-run clears the output
    apply(3, 1, 1, 1'b1, "R9 pre-reset");
    rst_n = 1'b0;
    #1;
    check(1'b0, "R1 async");
    @(negedge clk);
    check(1'b0, "R1 held");
    rst_n = 1'b1;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule